// File: doc/BRIEF.md
# SPI Receive Status and Match Flag Unit

This unit sits behind the serial shift engine of an SPI receiver. Each time the shifter finishes a frame it presents the word with a one-cycle valid pulse. The unit stores the word and raises a receive-full flag. It also compares the stored word against a software-written 16-bit match value and raises a match flag when they agree. Software or a DMA engine then empties the store, and software clears the flags through the register access strobes.

A static mode input selects one of two storage schemes. In buffer mode there is a single holding register: new words overwrite it, and the full flag means data is waiting. In FIFO mode there is a four-entry queue, and the full flag means every entry is occupied. Clearing uses two-step sequences, a status read followed by a data read or a write-one, so that a flag cannot be lost to a stray access. When DMA is enabled, the DMA completion pulse takes the place of the software sequence.

Top module: `spi_rx_status`

## Requirements
- R1: After reset, rxFull and matchHit are 0 and rxData is 0.
- R2: In buffer mode, a word presented with rxValid replaces the stored word. rxFull reads 1 from the next cycle and rxData shows the word. When wideFrame is 0, bits 15:8 are stored as zero.
- R3: In buffer mode with dmaEnable at 0, rxFull clears only on a dataRd that follows a statusRd pulse seen while rxFull was 1. A dataRd without that earlier status read leaves rxFull at 1. Each dataRd uses up the earlier status read.
- R4: In buffer mode, if a word arrives in the same cycle as a clearing dataRd or dmaDone, rxFull stays 1 and rxData shows the new word.
- R5: In buffer mode with dmaEnable at 1, a dmaDone pulse clears rxFull, and the statusRd-then-dataRd sequence does not clear it.
- R6: A stored word is compared in the cycle after it is stored, and matchHit takes the result one cycle later, but only if rxFull is 1 at comparison time. Equal words give matchHit = 1. The match value is loaded from matchIn on matchWr.
- R7: A compared word that differs from the match value sets matchHit to 0.
- R8: With wideFrame at 0, only bits 7:0 of the word and of the match value take part in the comparison.
- R9: matchHit clears when matchClrWr follows a statusRd pulse seen while matchHit was 1. A matchClrWr without that earlier status read leaves matchHit at 1.
- R10: In FIFO mode, rxFull is 1 exactly when the queue holds 4 words.
- R11: In FIFO mode, rxData shows the oldest word. A pop removes it. The pop comes from dataRd when dmaEnable is 0 and from dmaDone when dmaEnable is 1, with no status read needed. A word that arrives while the queue is full is discarded, unless a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifoMode | input | 1 | 0: single buffer, 1: four-entry queue (static) |
| wideFrame | input | 1 | 1: 16-bit frames, 0: 8-bit frames |
| dmaEnable | input | 1 | Receive DMA enabled |
| rxValid | input | 1 | Received-word pulse from the shifter |
| rxWord | input | 16 | Received word |
| matchWr | input | 1 | Load strobe for the match value |
| matchIn | input | 16 | Match value to load |
| statusRd | input | 1 | Status register read strobe |
| matchClrWr | input | 1 | Write-one strobe to the match flag bit |
| dataRd | input | 1 | Data register read strobe |
| dmaDone | input | 1 | Receive DMA completion pulse |
| rxFull | output | 1 | Receive-full flag |
| matchHit | output | 1 | Receive-match flag |
| rxData | output | 16 | Stored or oldest queued word |

## Verification
The hardest states to reach are the collisions: a word arriving in the same cycle as the access that would clear the flag, and a full queue that is popped and pushed in one cycle. The bench builds these by arming the status read first and then driving the data read together with rxValid on a single negative edge. It also sweeps families of words that differ from the match value in one bit, or only in the upper byte, in both frame widths, so that every equality and masking outcome is predicted arithmetically.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic push;       // append word at write pointer
    logic pop;        // retire oldest word
    logic overwrite;  // replace the word at read pointer (buffer mode)
  } rxs_strobe_t;
endpackage

// File: rtl/rxs_datapath.sv
module rxs_datapath
  import spi_rxs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wideFrame,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              matchWr,
  input  logic [DATA_W-1:0] matchIn,
  input  rxs_strobe_t       stb,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] headWord,
  output logic              wordEq
);
  localparam int HALF  = DATA_W / 2;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] lastWord, matchVal, storeWord;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    storeWord = wideFrame ? rxWord : {{(DATA_W-HALF){1'b0}}, rxWord[HALF-1:0]};
    headWord  = mem[rdPtr];
    wordEq    = wideFrame ? (lastWord == matchVal)
                          : (lastWord[HALF-1:0] == matchVal[HALF-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      lastWord <= '0;
      matchVal <= '0;
    end else begin
      if (stb.push) begin
        mem[wrPtr] <= storeWord;
        wrPtr      <= ptrInc(wrPtr);
      end
      if (stb.overwrite) mem[rdPtr] <= storeWord;
      if (stb.pop) rdPtr <= ptrInc(rdPtr);
      count <= count + CNT_W'(stb.push) - CNT_W'(stb.pop);
      if (stb.push || stb.overwrite) lastWord <= storeWord;
      if (matchWr) matchVal <= matchIn;
    end
  end
endmodule

// File: rtl/rxs_control.sv
module rxs_control
  import spi_rxs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifoMode,
  input  logic             dmaEnable,
  input  logic             rxValid,
  input  logic             statusRd,
  input  logic             dataRd,
  input  logic             dmaDone,
  input  logic             matchClrWr,
  input  logic [CNT_W-1:0] count,
  input  logic             wordEq,
  output rxs_strobe_t      stb,
  output logic             rxFull,
  output logic             matchHit
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic rdArm, matchArm, evalPend;
  logic notEmpty, clearReq, popReq, evalNow;

  always_comb begin
    notEmpty = (count != '0);
    rxFull   = fifoMode ? (count == FULL_CNT) : notEmpty;
    clearReq = dmaEnable ? dmaDone : (dataRd && rdArm);
    popReq   = dmaEnable ? dmaDone : dataRd;
    stb      = '0;
    if (fifoMode) begin
      stb.pop  = popReq && notEmpty;
      stb.push = rxValid && (!rxFull || stb.pop);
    end else begin
      stb.pop       = clearReq && notEmpty && !rxValid;
      stb.push      = rxValid && !notEmpty;
      stb.overwrite = rxValid && notEmpty;
    end
    evalNow = evalPend && rxFull;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdArm    <= 1'b0;
      matchArm <= 1'b0;
      evalPend <= 1'b0;
      matchHit <= 1'b0;
    end else begin
      evalPend <= stb.push || stb.overwrite;

      if (fifoMode || dmaEnable)  rdArm <= 1'b0;
      else if (statusRd && rxFull) rdArm <= 1'b1;
      else if (dataRd)             rdArm <= 1'b0;

      if (evalNow)                      matchHit <= wordEq;
      else if (matchClrWr && matchArm)  matchHit <= 1'b0;

      if (evalNow || matchClrWr)       matchArm <= 1'b0;
      else if (statusRd && matchHit)   matchArm <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rxs_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifoMode,
  input  logic              wideFrame,
  input  logic              dmaEnable,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              matchWr,
  input  logic [DATA_W-1:0] matchIn,
  input  logic              statusRd,
  input  logic              matchClrWr,
  input  logic              dataRd,
  input  logic              dmaDone,
  output logic              rxFull,
  output logic              matchHit,
  output logic [DATA_W-1:0] rxData
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  rxs_strobe_t      stb;
  logic [CNT_W-1:0] count;
  logic             wordEq;

  rxs_control #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fifoMode(fifoMode), .dmaEnable(dmaEnable),
    .rxValid(rxValid), .statusRd(statusRd), .dataRd(dataRd), .dmaDone(dmaDone),
    .matchClrWr(matchClrWr), .count(count), .wordEq(wordEq),
    .stb(stb), .rxFull(rxFull), .matchHit(matchHit)
  );

  rxs_datapath #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .wideFrame(wideFrame), .rxWord(rxWord),
    .matchWr(matchWr), .matchIn(matchIn), .stb(stb),
    .count(count), .headWord(rxData), .wordEq(wordEq)
  );
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifoMode,
  input logic              wideFrame,
  input logic              dmaEnable,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxWord,
  input logic              dataRd,
  input logic              dmaDone,
  input logic              matchClrWr,
  input logic              rxFull,
  input logic              matchHit,
  input logic [DATA_W-1:0] rxData
);
  localparam int HALF = DATA_W / 2;
  logic [DATA_W-1:0] expWord;
  assign expWord = wideFrame ? rxWord : {{(DATA_W-HALF){1'b0}}, rxWord[HALF-1:0]};

  // R2
  buf_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifoMode && rxValid) |=> (rxData == $past(expWord)));

  // R4
  arrival_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifoMode && rxValid) |=> rxFull);

  // R3
  full_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rxFull) && !fifoMode) |-> $past(dataRd || (dmaEnable && dmaDone)));

  // R6
  match_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matchHit) |-> $past(rxFull));

  // R9
  match_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(matchHit) |-> $past(matchClrWr || rxFull));

  // R10
  fifo_fill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoMode && $rose(rxFull)) |-> $past(rxValid));
endmodule

bind spi_rx_status rxs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifoMode(fifoMode), .wideFrame(wideFrame),
  .dmaEnable(dmaEnable), .rxValid(rxValid), .rxWord(rxWord), .dataRd(dataRd),
  .dmaDone(dmaDone), .matchClrWr(matchClrWr), .rxFull(rxFull),
  .matchHit(matchHit), .rxData(rxData)
);

// File: tb/spi_rx_status_tb.sv
module spi_rx_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifoMode = 1'b0, wideFrame = 1'b1, dmaEnable = 1'b0;
  logic rxValid = 1'b0, matchWr = 1'b0, statusRd = 1'b0;
  logic matchClrWr = 1'b0, dataRd = 1'b0, dmaDone = 1'b0;
  logic [15:0] rxWord = '0, matchIn = '0;
  logic rxFull, matchHit;
  logic [15:0] rxData;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spi_rx_status u_dut (
    .clk(clk), .rst_n(rst_n), .fifoMode(fifoMode), .wideFrame(wideFrame),
    .dmaEnable(dmaEnable), .rxValid(rxValid), .rxWord(rxWord),
    .matchWr(matchWr), .matchIn(matchIn), .statusRd(statusRd),
    .matchClrWr(matchClrWr), .dataRd(dataRd), .dmaDone(dmaDone),
    .rxFull(rxFull), .matchHit(matchHit), .rxData(rxData)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic sendWord(input logic [15:0] w);
    rxValid = 1'b1; rxWord = w; cyc(); rxValid = 1'b0;
  endtask
  task automatic pStatus(); statusRd = 1'b1; cyc(); statusRd = 1'b0; endtask
  task automatic pData();   dataRd = 1'b1;   cyc(); dataRd = 1'b0;   endtask
  task automatic pDma();    dmaDone = 1'b1;  cyc(); dmaDone = 1'b0;  endtask
  task automatic pClr();    matchClrWr = 1'b1; cyc(); matchClrWr = 1'b0; endtask
  task automatic setMatch(input logic [15:0] m);
    matchWr = 1'b1; matchIn = m; cyc(); matchWr = 1'b0;
  endtask
  task automatic doReset();
    rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [15:0] w, q [4];
    cyc();
    doReset();
    // R1 reset state
    chk("R1 rxFull", {15'b0, rxFull}, 16'h0);
    chk("R1 matchHit", {15'b0, matchHit}, 16'h0);
    chk("R1 rxData", rxData, 16'h0);

    setMatch(16'h3C5A);
    // R2 store and flag
    sendWord(16'h1234);
    chk("R2 rxFull", {15'b0, rxFull}, 16'h1);
    chk("R2 rxData", rxData, 16'h1234);
    cyc();
    chk("R7 mismatch", {15'b0, matchHit}, 16'h0);
    // R3 data read without status read ignored
    pData();
    chk("R3 unarmed read", {15'b0, rxFull}, 16'h1);
    pStatus(); pData();
    chk("R3 sequence clears", {15'b0, rxFull}, 16'h0);

    // R4 arrival collides with clearing read
    sendWord(16'h0001);
    pStatus();
    dataRd = 1'b1; rxValid = 1'b1; rxWord = 16'h0002; cyc();
    dataRd = 1'b0; rxValid = 1'b0;
    chk("R4 flag kept", {15'b0, rxFull}, 16'h1);
    chk("R4 new word", rxData, 16'h0002);
    pData();
    chk("R3 arm consumed", {15'b0, rxFull}, 16'h1);
    pStatus(); pData();
    chk("R3 clear again", {15'b0, rxFull}, 16'h0);

    // R5 DMA clearing
    dmaEnable = 1'b1;
    sendWord(16'h0BEE);
    pStatus(); pData();
    chk("R5 software seq ignored", {15'b0, rxFull}, 16'h1);
    pDma();
    chk("R5 dma clears", {15'b0, rxFull}, 16'h0);
    sendWord(16'h0C00);
    dmaDone = 1'b1; rxValid = 1'b1; rxWord = 16'h0C01; cyc();
    dmaDone = 1'b0; rxValid = 1'b0;
    chk("R4 dma collision", {15'b0, rxFull}, 16'h1);
    dmaEnable = 1'b0;

    // R6 R7 wide sweep: odd i equal, even i differ in one bit
    for (int i = 0; i < 16; i++) begin
      w = (i % 2 == 1) ? 16'h3C5A : (16'h3C5A ^ (16'h1 << i));
      sendWord(w); cyc();
      chk((i % 2 == 1) ? "R6 wide equal" : "R7 wide differ",
          {15'b0, matchHit}, (i % 2 == 1) ? 16'h1 : 16'h0);
    end

    // R8 narrow sweep: upper byte varies, low byte equal on odd i
    wideFrame = 1'b0;
    for (int i = 0; i < 8; i++) begin
      w = {8'(i * 37 + 1), (i % 2 == 1) ? 8'h5A : 8'(i)};
      sendWord(w);
      chk("R2 narrow store", rxData, {8'h00, w[7:0]});
      cyc();
      chk("R8 narrow compare", {15'b0, matchHit}, (i % 2 == 1) ? 16'h1 : 16'h0);
    end
    wideFrame = 1'b1;

    // R9 match clear sequence
    sendWord(16'h3C5A); cyc();
    chk("R9 set", {15'b0, matchHit}, 16'h1);
    pClr();
    chk("R9 unarmed write", {15'b0, matchHit}, 16'h1);
    pStatus(); pClr();
    chk("R9 armed clear", {15'b0, matchHit}, 16'h0);

    // FIFO mode
    fifoMode = 1'b1;
    doReset();
    for (int k = 0; k < 4; k++) q[k] = 16'hA000 + 16'(k * 17);
    setMatch(q[1]);
    sendWord(q[0]);
    chk("R10 one entry", {15'b0, rxFull}, 16'h0);
    sendWord(q[1]);
    chk("R10 two entries", {15'b0, rxFull}, 16'h0);
    sendWord(q[2]);
    chk("R10 three entries", {15'b0, rxFull}, 16'h0);
    chk("R6 not full no match", {15'b0, matchHit}, 16'h0);
    setMatch(q[3]);
    sendWord(q[3]);
    chk("R10 four entries", {15'b0, rxFull}, 16'h1);
    cyc();
    chk("R6 full match", {15'b0, matchHit}, 16'h1);
    sendWord(16'hDEAD);
    chk("R11 discard keeps full", {15'b0, rxFull}, 16'h1);
    chk("R11 head oldest", rxData, q[0]);
    dataRd = 1'b1; rxValid = 1'b1; rxWord = 16'hB055; cyc();
    dataRd = 1'b0; rxValid = 1'b0;
    chk("R11 pop and push", {15'b0, rxFull}, 16'h1);
    chk("R11 head advanced", rxData, q[1]);
    dmaEnable = 1'b1;
    pData();
    chk("R11 read ignored with dma", rxData, q[1]);
    pDma();
    chk("R10 dma pop unfills", {15'b0, rxFull}, 16'h0);
    chk("R11 order 2", rxData, q[2]);
    dmaEnable = 1'b0;
    pData();
    chk("R11 order 3", rxData, q[3]);
    pData();
    chk("R11 order 4", rxData, 16'hB055);
    pData();
    chk("R10 empty", {15'b0, rxFull}, 16'h0);

    finishRun();
  end
endmodule